// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Divider Controller

This block sits behind an external dual-modulus prescaler in a frequency-synthesizer feedback path. It runs on the prescaler's output clock and counts prescaler periods. It also drives the prescaler's modulus-control line. Within every output cycle of N prescaler periods, the first A periods divide by M+1 and the remaining N−A periods divide by M. The oscillator path is therefore divided by M·N+A in total. At the end of each cycle, one divided-output pulse goes to the phase detector.

The base modulus is 64 or 128, and the caller selects it through `wide_sel`. The block latches that selection together with N and A at every reload boundary. The latched value is presented on `wide_out`, so that the prescaler's base modulus changes on the same boundary as the counts.

The control is a three-state machine:

| State | Meaning |
|---|---|
| `ST_IDLE` | Entered from reset. |
| `ST_SWALLOW` | Modulus control is high. |
| `ST_BASE` | Modulus control is low. |

Transitions:
- **IDLE→SWALLOW / IDLE→BASE:** the first clock after reset is a reload. The machine enters SWALLOW if the loaded A is nonzero, and BASE otherwise.
- **SWALLOW→BASE:** taken when the swallow counter is on its last period.
- **SWALLOW→SWALLOW and BASE→BASE:** taken while counting continues.
- **Any running state → reload:** taken when the main counter is on its last period. The pulse is emitted in that period. The next state is again chosen by whether the newly loaded A is zero.

Top module: `psw_divctl`

## Requirements
- R1: For legal settings (3 ≤ N ≤ 2047, 0 ≤ A ≤ 127, A < N), the sum of prescaler input edges over one output cycle equals M·N+A. Here M is 128 when `wide_out` is 1 and 64 when it is 0, and a period with `mod_ctl`=1 divides by M+1.
- R2: `div_pulse` is high for exactly one prescaler period and occurs once every N periods.
- R3: Within an output cycle, `mod_ctl` is 1 for the first A periods and 0 for the following N−A periods. It is 0 in the pulse period.
- R4: When A is 0, `mod_ctl` stays 0 for the whole cycle.
- R5: Changes to `n_val` and `a_val` in the middle of a cycle do not alter that cycle. They apply from the next reload.
- R6: `wide_sel` is latched only at a reload. `wide_out` stays constant throughout a cycle.
- R7: While reset is asserted, `mod_ctl`, `div_pulse` and `wide_out` are 0. The first clock after release performs a reload, and the first cycle has the full length N.
- R8: The extreme settings (N=2047 with A=127, N=3 with A=2, N=3 with A=0, and A=127 with a small N) all obey R1 to R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Prescaler output clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| n_val | input | 11 | Main count N |
| a_val | input | 7 | Swallow count A |
| wide_sel | input | 1 | Base modulus select: 1 = 128, 0 = 64 |
| mod_ctl | output | 1 | 1 = prescaler divides by M+1, 0 = by M |
| wide_out | output | 1 | Latched base modulus select for the prescaler |
| div_pulse | output | 1 | One-period pulse at the end of each output cycle |

## Verification
The hardest case to reach is a settings change that lands inside a running cycle. In that case the old cycle must finish untouched while the new values are already waiting on the inputs.

The bench aligns to the output pulse and counts prescaler periods from there. It changes N, A and the base modulus at a chosen period in the middle of the cycle. It then verifies that the edge total for that cycle still matches the old settings, and that the following cycle matches the new ones.

Reaching the N=2047 boundary needs no special path. The prescaler is modelled as an edge accumulator that adds M or M+1 per period, so long cycles stay short in clock count.

// File: rtl/psw_pkg.sv
package psw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SWALLOW = 2'd1,
        ST_BASE    = 2'd2
    } psw_state_e;

endpackage

// File: rtl/psw_dcount.sv
// Loadable down-counter; flags the final period of a count.
module psw_dcount #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         is_one
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec) begin
            cnt <= cnt - ONE;
        end
    end

    assign is_one = (cnt == ONE);
endmodule

// File: rtl/psw_fsm.sv
// Swallow / base sequencing state machine.
module psw_fsm
    import psw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic n_is_one,
    input  logic a_is_one,
    input  logic a_load_zero,
    output logic reload,
    output logic dec_n,
    output logic dec_a,
    output logic mod_ctl,
    output logic div_pulse
);
    psw_state_e state, state_nx;
    psw_state_e after_load;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next state.
    always_comb begin
        after_load = a_load_zero ? ST_BASE : ST_SWALLOW;
        state_nx   = state;
        unique case (state)
            ST_IDLE: begin
                state_nx = after_load;
            end
            ST_SWALLOW: begin
                if (n_is_one) begin
                    state_nx = after_load;
                end else if (a_is_one) begin
                    state_nx = ST_BASE;
                end
            end
            ST_BASE: begin
                if (n_is_one) begin
                    state_nx = after_load;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        reload    = (state == ST_IDLE) || n_is_one;
        dec_n     = !reload;
        dec_a     = (state == ST_SWALLOW) && !reload;
        mod_ctl   = (state == ST_SWALLOW);
        div_pulse = (state != ST_IDLE) && n_is_one;
    end
endmodule

// File: rtl/psw_divctl.sv
// Pulse-swallow dual-modulus divider controller (top).
module psw_divctl #(
    parameter int N_W = 11,
    parameter int A_W = 7
) (
    input  logic           pclk,
    input  logic           rst_n,
    input  logic [N_W-1:0] n_val,
    input  logic [A_W-1:0] a_val,
    input  logic           wide_sel,
    output logic           mod_ctl,
    output logic           wide_out,
    output logic           div_pulse
);
    logic reload, dec_n, dec_a;
    logic n_is_one, a_is_one;
    logic wide_q;

    psw_dcount #(.W(N_W)) i_ncnt (
        .clk      (pclk),
        .rst_n    (rst_n),
        .load     (reload),
        .load_val (n_val),
        .dec      (dec_n),
        .is_one   (n_is_one)
    );

    psw_dcount #(.W(A_W)) i_acnt (
        .clk      (pclk),
        .rst_n    (rst_n),
        .load     (reload),
        .load_val (a_val),
        .dec      (dec_a),
        .is_one   (a_is_one)
    );

    psw_fsm i_fsm (
        .clk         (pclk),
        .rst_n       (rst_n),
        .n_is_one    (n_is_one),
        .a_is_one    (a_is_one),
        .a_load_zero (a_val == '0),
        .reload      (reload),
        .dec_n       (dec_n),
        .dec_a       (dec_a),
        .mod_ctl     (mod_ctl),
        .div_pulse   (div_pulse)
    );

    // Base modulus select, captured only on a cycle boundary.
    always_ff @(posedge pclk or negedge rst_n) begin
        if (!rst_n) begin
            wide_q <= 1'b0;
        end else if (reload) begin
            wide_q <= wide_sel;
        end
    end

    assign wide_out = wide_q;
endmodule

// File: rtl/psw_divctl_chk.sv
module psw_divctl_chk #(
    parameter int N_W = 11,
    parameter int A_W = 7
) (
    input logic           pclk,
    input logic           rst_n,
    input logic [N_W-1:0] n_val,
    input logic [A_W-1:0] a_val,
    input logic           wide_sel,
    input logic           mod_ctl,
    input logic           wide_out,
    input logic           div_pulse
);
    logic started;

    always_ff @(posedge pclk or negedge rst_n) begin
        if (!rst_n) begin
            started <= 1'b0;
        end else begin
            started <= 1'b1;
        end
    end

    a_r2_pulse_one_wide: assert property (@(posedge pclk) disable iff (!rst_n)
        div_pulse |=> !div_pulse);

    a_r3_no_swallow_after_base: assert property (@(posedge pclk) disable iff (!rst_n)
        started && !mod_ctl && !div_pulse |=> !mod_ctl);

    a_r3_base_at_pulse: assert property (@(posedge pclk) disable iff (!rst_n)
        div_pulse |-> !mod_ctl);

    a_r4_zero_swallow: assert property (@(posedge pclk) disable iff (!rst_n)
        started && div_pulse && (a_val == '0) |=> !mod_ctl);

    a_r6_modulus_hold: assert property (@(posedge pclk) disable iff (!rst_n)
        started && !div_pulse |=> $stable(wide_out));

    a_r7_idle_quiet: assert property (@(posedge pclk) disable iff (!rst_n)
        !started |-> !div_pulse && !mod_ctl && !wide_out);

    logic unused_ok;
    assign unused_ok = ^{n_val, wide_sel};
endmodule

bind psw_divctl psw_divctl_chk #(.N_W(N_W), .A_W(A_W)) i_chk (
    .pclk      (pclk),
    .rst_n     (rst_n),
    .n_val     (n_val),
    .a_val     (a_val),
    .wide_sel  (wide_sel),
    .mod_ctl   (mod_ctl),
    .wide_out  (wide_out),
    .div_pulse (div_pulse)
);

// File: tb/test_psw_divctl.sv
`timescale 1ns/1ps
module test_psw_divctl;
    logic        pclk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] n_val = 11'd5;
    logic [6:0]  a_val = 7'd2;
    logic        wide_sel = 1'b0;
    logic        mod_ctl, wide_out, div_pulse;

    int n_chk = 0;
    int n_err = 0;

    always #2 pclk = ~pclk;

    psw_divctl i_psw_divctl (
        .pclk      (pclk),
        .rst_n     (rst_n),
        .n_val     (n_val),
        .a_val     (a_val),
        .wide_sel  (wide_sel),
        .mod_ctl   (mod_ctl),
        .wide_out  (wide_out),
        .div_pulse (div_pulse)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Prescaler model: each sampled period adds M or M+1 input edges.
    task automatic measure(input int chg_at, input int n2, input int a2, input bit w2,
                           output int vco, output int len, output int hi,
                           output bit order_ok, output bit wide_const);
        bit seen_lo;
        bit w0;
        vco = 0; len = 0; hi = 0; order_ok = 1'b1; wide_const = 1'b1;
        seen_lo = 1'b0; w0 = 1'b0;
        for (int g = 0; g < 5000; g++) begin
            @(negedge pclk);
            if (len == 0) w0 = wide_out;
            else if (wide_out != w0) wide_const = 1'b0;
            vco += (wide_out ? 128 : 64) + (mod_ctl ? 1 : 0);
            if (mod_ctl) begin
                hi++;
                if (seen_lo) order_ok = 1'b0;
            end else begin
                seen_lo = 1'b1;
            end
            len++;
            if (len == chg_at) begin
                n_val = 11'(n2); a_val = 7'(a2); wide_sel = w2;
            end
            if (div_pulse) return;
        end
        check(1'b0, "measure timeout", len, 0);
    endtask

    task automatic t_reset();
        int vco, len, hi; bit ok, wc;
        rst_n = 1'b0; n_val = 11'd5; a_val = 7'd2; wide_sel = 1'b1;
        repeat (3) @(negedge pclk);
        check(!mod_ctl,   "R7 mod_ctl in reset",   int'(mod_ctl),   0);
        check(!div_pulse, "R7 div_pulse in reset", int'(div_pulse), 0);
        check(!wide_out,  "R7 wide_out in reset",  int'(wide_out),  0);
        rst_n = 1'b1;
        @(negedge pclk);
        check(mod_ctl,  "R7 first reload mod_ctl",  int'(mod_ctl),  1);
        check(wide_out, "R7 first reload wide_out", int'(wide_out), 1);
        measure(-1, 0, 0, 1'b0, vco, len, hi, ok, wc);
        check(len + 1 == 5, "R7 first cycle length", len + 1, 5);
        check(vco + 129 == 128 * 5 + 2, "R7 first cycle ratio", vco + 129, 642);
    endtask

    task automatic t_ratio(input int n, input int a, input bit w, input string tag);
        int vco, len, hi; bit ok, wc;
        int m;
        m = w ? 128 : 64;
        n_val = 11'(n); a_val = 7'(a); wide_sel = w;
        measure(-1, 0, 0, 1'b0, vco, len, hi, ok, wc);
        measure(-1, 0, 0, 1'b0, vco, len, hi, ok, wc);
        check(vco == m * n + a, {"R1 ratio ", tag}, vco, m * n + a);
        check(len == n, {"R2 pulse spacing ", tag}, len, n);
        check(hi == a && ok, {"R3 swallow periods ", tag}, hi, a);
        if (a == 0) check(hi == 0, {"R4 zero swallow ", tag}, hi, 0);
    endtask

    task automatic t_width();
        int vco, len, hi; bit ok, wc;
        n_val = 11'd3; a_val = 7'd1; wide_sel = 1'b0;
        measure(-1, 0, 0, 1'b0, vco, len, hi, ok, wc);
        measure(-1, 0, 0, 1'b0, vco, len, hi, ok, wc);
        @(negedge pclk);
        check(!div_pulse, "R2 pulse one period wide", int'(div_pulse), 0);
        check(mod_ctl, "R3 swallow resumes after pulse", int'(mod_ctl), 1);
    endtask

    task automatic t_midchange();
        int vco, len, hi; bit ok, wc;
        n_val = 11'd20; a_val = 7'd5; wide_sel = 1'b0;
        measure(-1, 0, 0, 1'b0, vco, len, hi, ok, wc);
        measure(-1, 0, 0, 1'b0, vco, len, hi, ok, wc);
        measure(7, 30, 10, 1'b1, vco, len, hi, ok, wc);
        check(vco == 64 * 20 + 5, "R5 old cycle kept", vco, 64 * 20 + 5);
        check(len == 20, "R5 old length kept", len, 20);
        check(wc && !wide_out, "R6 modulus held mid cycle", int'(wide_out), 0);
        measure(-1, 0, 0, 1'b0, vco, len, hi, ok, wc);
        check(vco == 128 * 30 + 10, "R5 new settings applied", vco, 128 * 30 + 10);
        check(wide_out, "R6 modulus taken at boundary", int'(wide_out), 1);
    endtask

    initial begin
        int seed;
        seed = 7;
        void'($urandom(seed));
        t_reset();
        t_width();
        t_midchange();
        for (int w = 0; w < 2; w++) begin
            for (int k = 0; k < 4; k++) begin
                int n, a, amax;
                n = 3 + int'($urandom_range(300, 0));
                amax = (n - 1 < 127) ? n - 1 : 127;
                a = int'($urandom_range(amax, 0));
                t_ratio(n, a, w[0], "random");
            end
        end
        t_ratio(40, 0, 1'b0, "R4 A=0 M=64");
        t_ratio(2047, 127, 1'b1, "R8 max");
        t_ratio(3, 2, 1'b0, "R8 N=3 A=2");
        t_ratio(3, 0, 1'b1, "R8 N=3 A=0");
        t_ratio(128, 127, 1'b0, "R8 A=127");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #600000;
        check(1'b0, "watchdog expired", 0, 1);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule